// File: doc/BRIEF.md
# ECC Error History and Interrupt Unit

This unit sits beside a memory ECC checker and keeps a running history of the faults that checker reports. Three error classes arrive as single-cycle event strobes: corrected single-bit errors, detected double-bit errors and address errors. Each strobe comes with the failing address, and a single-bit event also carries the corrected codeword bit position.

For each class the unit keeps a saturating event counter and a short trace that records failing addresses in order of arrival. A programmable threshold raises that class's interrupt line. A per-class write-one-to-clear control wipes the counter and the trace together. An optional mode keeps only unique addresses in the traces. A sticky vector marks every codeword bit position that has ever been corrected, and it has its own clear bit.

Software reaches all of this through a simple word-wide register port. Reads are combinational from `reg_addr`. Writes take effect at the rising clock edge while `reg_we` is high.

Top module: `ecc_err_hist`

## Requirements
- R1: After synchronous reset, the config word (offset 0x01) reads 0x0011_0001: single-error threshold in bits 15:0 = 1, double-error threshold in bits 19:16 = 1, address-error threshold in bits 23:20 = 1, duplicate-discard in bit 24 = 0. After reset all counts, trace levels, trace entries and distribution words read 0, and all three interrupts are low.
- R2: An event strobe of one class raises that class's count (offsets 0x02 single, 0x03 double, 0x04 address) by exactly one in the cycle after the strobe, and leaves the other classes unchanged.
- R3: Counts are CNT_W bits wide and hold at 2^CNT_W-1 instead of wrapping.
- R4: A class interrupt is high exactly while its threshold is nonzero and its count is at least the threshold. A threshold of zero never raises it. A threshold above the largest count never raises it.
- R5: Each trace stores failing addresses in arrival order. Entry i of class c reads at offset 0x08+8c+i (c = 0 single, 1 double, 2 address). The fill level reads at offsets 0x05 to 0x07. Once DEPTH entries are held, further addresses are dropped while the count keeps rising.
- R6: With config bit 24 set, an address already present in that class's trace is not stored again, although it is still counted. With bit 24 clear, every address is stored.
- R7: Writing offset 0x00 with bit 0, 1 or 2 set clears the single, double or address class respectively: count, level and trace entries all go to 0, and so does its interrupt. Classes whose bit is 0 are untouched.
- R8: When a class clear and an event of that class occur in the same cycle, the clear wins and the class is left empty.
- R9: Each single-bit event with a position below NBITS sets that bit of a sticky NBITS-bit vector, read LSB-first as 32-bit words at offsets 0x20 upward. Positions of NBITS or more are ignored. Writing bit 3 of offset 0x00 zeroes the vector without touching any count.
- R10: Offset 0x00 always reads 0. Config bits 31:25 read 0 whatever is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_ev | input | 1 | Corrected single-bit error strobe |
| sec_addr | input | AW | Failing address of the single-bit error |
| sec_bit | input | PW | Corrected codeword bit position |
| ded_ev | input | 1 | Double-bit error strobe |
| ded_addr | input | AW | Failing address of the double-bit error |
| adr_ev | input | 1 | Address error strobe |
| adr_addr | input | AW | Failing address of the address error |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 6 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq_sec | output | 1 | Single-bit class interrupt |
| irq_ded | output | 1 | Double-bit class interrupt |
| irq_adr | output | 1 | Address-error class interrupt |

## Verification
The bench builds the unit with CNT_W = 5, AW = 8 and DEPTH = 4, and keeps NBITS at its default of 137. A 5-bit count saturates after 31 events, so the saturation edge is reached in a few dozen cycles. Every 4-bit double-error threshold, from 0 to 15, is swept against counts 1 to 17, and each expected interrupt level is computed arithmetically. The four-entry traces make the full-drop and duplicate-skip cases reachable with short address sequences, and the distribution vector is probed at its word boundaries and at its last bit.

// File: rtl/ecc_hist_pkg.sv
package ecc_hist_pkg;

    localparam int NUM_CLASS = 3;
    localparam int SEC_THR_W = 16;
    localparam int DED_THR_W = 4;
    localparam int ADR_THR_W = 4;
    localparam int RA_W      = 6;
    localparam int DW        = 32;

    typedef enum logic [1:0] {
        CLS_SEC = 2'd0,
        CLS_DED = 2'd1,
        CLS_ADR = 2'd2
    } err_class_e;

    // register offsets
    localparam logic [RA_W-1:0] OFS_CLEAR = 6'h00;
    localparam logic [RA_W-1:0] OFS_CFG   = 6'h01;
    localparam int OFS_CNT_BASE   = 2;
    localparam int OFS_LVL_BASE   = 5;
    localparam int OFS_TRACE_BASE = 8;
    localparam int TRACE_STRIDE   = 8;
    localparam int OFS_DIST_BASE  = 32;

    // clear-register bit positions
    localparam int CLR_SEC_BIT  = 0;
    localparam int CLR_DED_BIT  = 1;
    localparam int CLR_ADR_BIT  = 2;
    localparam int CLR_DIST_BIT = 3;
    localparam int CLR_W        = 4;

    typedef struct packed {
        logic                 discard_dup;
        logic [ADR_THR_W-1:0] adr_thr;
        logic [DED_THR_W-1:0] ded_thr;
        logic [SEC_THR_W-1:0] sec_thr;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    localparam cfg_t CFG_RESET = '{
        discard_dup: 1'b0,
        adr_thr:     ADR_THR_W'(1),
        ded_thr:     DED_THR_W'(1),
        sec_thr:     SEC_THR_W'(1)
    };

    function automatic int dist_words(input int nbits);
        return (nbits + DW - 1) / DW;
    endfunction

endpackage

// File: rtl/ecc_class_trace.sv
module ecc_class_trace #(
    parameter int AW    = 16,
    parameter int DEPTH = 4,
    parameter int CNT_W = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ev_valid,
    input  logic [AW-1:0]       ev_addr,
    input  logic                clr,
    input  logic                discard_dup,
    output logic [CNT_W-1:0]    count,
    output logic [LVL_W-1:0]    level,
    output logic [DEPTH*AW-1:0] trace_flat
);

    logic [AW-1:0] mem [DEPTH];
    logic          dup_hit;
    logic          full;
    logic          store;

    always_comb begin
        dup_hit = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (LVL_W'(i) < level && mem[i] == ev_addr) dup_hit = 1'b1;
        end
    end

    assign full  = (level == LVL_W'(DEPTH));
    assign store = ev_valid && !full && !(discard_dup && dup_hit);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
            level <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (ev_valid && count != '1) count <= count + CNT_W'(1);
            if (store) begin
                level <= level + LVL_W'(1);
                for (int i = 0; i < DEPTH; i++) begin
                    if (LVL_W'(i) == level) mem[i] <= ev_addr;
                end
            end
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_flat
            assign trace_flat[g*AW +: AW] = mem[g];
        end
    endgenerate

endmodule

// File: rtl/ecc_thresh_irq.sv
module ecc_thresh_irq #(
    parameter int CNT_W = 16,
    parameter int THR_W = 4,
    localparam int MW = (CNT_W > THR_W) ? CNT_W : THR_W
) (
    input  logic [CNT_W-1:0] count,
    input  logic [THR_W-1:0] thr,
    output logic             irq
);

    logic [MW-1:0] cnt_ext;
    logic [MW-1:0] thr_ext;

    assign cnt_ext = MW'(count);
    assign thr_ext = MW'(thr);
    assign irq     = (thr != '0) && (cnt_ext >= thr_ext);

endmodule

// File: rtl/ecc_bit_distr.sv
module ecc_bit_distr #(
    parameter int NBITS = 137,
    localparam int PW = $clog2(NBITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             hit,
    input  logic [PW-1:0]    pos,
    output logic [NBITS-1:0] marks
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            marks <= '0;
        end else if (hit) begin
            for (int i = 0; i < NBITS; i++) begin
                if (pos == PW'(i)) marks[i] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ecc_err_hist.sv
module ecc_err_hist
    import ecc_hist_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DEPTH = 4,
    parameter int CNT_W = 16,
    parameter int NBITS = 137,
    localparam int PW     = $clog2(NBITS),
    localparam int LVL_W  = $clog2(DEPTH + 1),
    localparam int NWORDS = dist_words(NBITS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sec_ev,
    input  logic [AW-1:0]   sec_addr,
    input  logic [PW-1:0]   sec_bit,
    input  logic            ded_ev,
    input  logic [AW-1:0]   ded_addr,
    input  logic            adr_ev,
    input  logic [AW-1:0]   adr_addr,
    input  logic            reg_we,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic            irq_sec,
    output logic            irq_ded,
    output logic            irq_adr
);

    cfg_t               cfg_q;
    logic [CLR_W-1:0]   clr_vec;
    logic               ev_v   [NUM_CLASS];
    logic [AW-1:0]      ev_a   [NUM_CLASS];
    logic [CNT_W-1:0]   cnt    [NUM_CLASS];
    logic [LVL_W-1:0]   lvl    [NUM_CLASS];
    logic [DEPTH*AW-1:0] trace [NUM_CLASS];
    logic [NBITS-1:0]   dist_marks;
    logic [NWORDS*DW-1:0] dist_pad;

    // configuration register
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (reg_we && reg_addr == OFS_CFG) begin
            cfg_q <= cfg_t'(reg_wdata[CFG_W-1:0]);
        end
    end

    // clear pulses act at the same edge as the write
    assign clr_vec = (reg_we && reg_addr == OFS_CLEAR) ? reg_wdata[CLR_W-1:0] : '0;

    assign ev_v[CLS_SEC] = sec_ev;
    assign ev_v[CLS_DED] = ded_ev;
    assign ev_v[CLS_ADR] = adr_ev;
    assign ev_a[CLS_SEC] = sec_addr;
    assign ev_a[CLS_DED] = ded_addr;
    assign ev_a[CLS_ADR] = adr_addr;

    generate
        for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
            ecc_class_trace #(
                .AW    (AW),
                .DEPTH (DEPTH),
                .CNT_W (CNT_W)
            ) u_trace (
                .clk         (clk),
                .rst         (rst),
                .ev_valid    (ev_v[c]),
                .ev_addr     (ev_a[c]),
                .clr         (clr_vec[c]),
                .discard_dup (cfg_q.discard_dup),
                .count       (cnt[c]),
                .level       (lvl[c]),
                .trace_flat  (trace[c])
            );
        end
    endgenerate

    ecc_thresh_irq #(.CNT_W(CNT_W), .THR_W(SEC_THR_W)) u_irq_sec (
        .count (cnt[CLS_SEC]),
        .thr   (cfg_q.sec_thr),
        .irq   (irq_sec)
    );

    ecc_thresh_irq #(.CNT_W(CNT_W), .THR_W(DED_THR_W)) u_irq_ded (
        .count (cnt[CLS_DED]),
        .thr   (cfg_q.ded_thr),
        .irq   (irq_ded)
    );

    ecc_thresh_irq #(.CNT_W(CNT_W), .THR_W(ADR_THR_W)) u_irq_adr (
        .count (cnt[CLS_ADR]),
        .thr   (cfg_q.adr_thr),
        .irq   (irq_adr)
    );

    ecc_bit_distr #(.NBITS(NBITS)) u_distr (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr_vec[CLR_DIST_BIT]),
        .hit   (sec_ev),
        .pos   (sec_bit),
        .marks (dist_marks)
    );

    assign dist_pad = (NWORDS*DW)'(dist_marks);

    // read multiplexer; the clear offset falls through to zero
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFS_CFG) reg_rdata = DW'(cfg_q);
        for (int c = 0; c < NUM_CLASS; c++) begin
            if (reg_addr == RA_W'(OFS_CNT_BASE + c)) reg_rdata = DW'(cnt[c]);
            if (reg_addr == RA_W'(OFS_LVL_BASE + c)) reg_rdata = DW'(lvl[c]);
            for (int i = 0; i < DEPTH; i++) begin
                if (reg_addr == RA_W'(OFS_TRACE_BASE + TRACE_STRIDE*c + i))
                    reg_rdata = DW'(trace[c][i*AW +: AW]);
            end
        end
        for (int w = 0; w < NWORDS; w++) begin
            if (reg_addr == RA_W'(OFS_DIST_BASE + w)) reg_rdata = dist_pad[w*DW +: DW];
        end
    end

endmodule

// File: rtl/ecc_err_hist_chk.sv
module ecc_err_hist_chk #(
    parameter int CNT_W = 16,
    parameter int LVL_W = 3,
    parameter int DEPTH = 4,
    parameter int NBITS = 137,
    parameter int THR_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [3:0]       clr_vec,
    input logic             sec_ev,
    input logic [CNT_W-1:0] sec_cnt,
    input logic [LVL_W-1:0] sec_lvl,
    input logic [THR_W-1:0] ded_thr,
    input logic             irq_ded,
    input logic [NBITS-1:0] marks
);

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (sec_ev && !clr_vec[0] && sec_cnt != '1) |=> sec_cnt == $past(sec_cnt) + CNT_W'(1));

    // R3
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_vec[0] |=> sec_cnt >= $past(sec_cnt));

    // R4
    zero_thr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ded_thr == '0) |-> !irq_ded);

    // R5
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        sec_lvl <= LVL_W'(DEPTH));

    // R8
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        clr_vec[0] |=> (sec_cnt == '0 && sec_lvl == '0));

    // R9
    distr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_vec[3] |=> (marks & $past(marks)) == $past(marks));

endmodule

bind ecc_err_hist ecc_err_hist_chk #(
    .CNT_W (CNT_W),
    .LVL_W (LVL_W),
    .DEPTH (DEPTH),
    .NBITS (NBITS),
    .THR_W (ecc_hist_pkg::DED_THR_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .clr_vec (clr_vec),
    .sec_ev  (sec_ev),
    .sec_cnt (cnt[0]),
    .sec_lvl (lvl[0]),
    .ded_thr (cfg_q.ded_thr),
    .irq_ded (irq_ded),
    .marks   (dist_marks)
);

// File: tb/ecc_err_hist_test.sv
`timescale 1ns/1ps
module ecc_err_hist_test;

    localparam int AW    = 8;
    localparam int DEPTH = 4;
    localparam int CNT_W = 5;
    localparam int NBITS = 137;
    localparam int PW    = $clog2(NBITS);
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            sec_ev = 0, ded_ev = 0, adr_ev = 0;
    logic [AW-1:0]   sec_addr = 0, ded_addr = 0, adr_addr = 0;
    logic [PW-1:0]   sec_bit = 0;
    logic            reg_we = 0;
    logic [5:0]      reg_addr = 0;
    logic [31:0]     reg_wdata = 0;
    logic [31:0]     reg_rdata;
    logic            irq_sec, irq_ded, irq_adr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    ecc_err_hist #(.AW(AW), .DEPTH(DEPTH), .CNT_W(CNT_W), .NBITS(NBITS)) uut (
        .clk(clk), .rst(rst),
        .sec_ev(sec_ev), .sec_addr(sec_addr), .sec_bit(sec_bit),
        .ded_ev(ded_ev), .ded_addr(ded_addr),
        .adr_ev(adr_ev), .adr_addr(adr_addr),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .irq_sec(irq_sec), .irq_ded(irq_ded), .irq_adr(irq_adr)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0; reg_wdata = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic rdchk(input string req, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    // cls: 0 single, 1 double, 2 address
    task automatic fire(input int cls, input logic [AW-1:0] a, input logic [PW-1:0] b);
        @(negedge clk);
        case (cls)
            0: begin sec_ev = 1; sec_addr = a; sec_bit = b; end
            1: begin ded_ev = 1; ded_addr = a; end
            default: begin adr_ev = 1; adr_addr = a; end
        endcase
        @(negedge clk);
        sec_ev = 0; ded_ev = 0; adr_ev = 0;
    endtask

    function automatic logic [5:0] tofs(input int cls, input int i);
        return 6'(8 + 8*cls + i);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        rdchk("R1 cfg", 6'h01, 32'h0011_0001);
        for (int c = 0; c < 3; c++) begin
            rdchk("R1 count", 6'(2 + c), 0);
            rdchk("R1 level", 6'(5 + c), 0);
            for (int i = 0; i < DEPTH; i++) rdchk("R1 trace", tofs(c, i), 0);
        end
        for (int w = 0; w < 5; w++) rdchk("R1 distr", 6'(32 + w), 0);
        check("R1 irqs", {29'd0, irq_sec, irq_ded, irq_adr}, 0);

        // R10 clear reads zero, reserved cfg bits
        wr(6'h01, 32'hFFFF_FFFF);
        rdchk("R10 cfg reserved", 6'h01, 32'h01FF_FFFF);
        wr(6'h00, 32'h0000_000F);
        rdchk("R10 clear reads 0", 6'h00, 0);
        wr(6'h01, 32'h0011_0001);

        // R2 R4 sweep of double-error threshold against counts
        for (int thr = 0; thr < 16; thr++) begin
            wr(6'h00, 32'h2);
            wr(6'h01, {7'd0, 1'b0, 4'd1, 4'(thr), 16'd1});
            for (int n = 1; n <= 17; n++) begin
                fire(1, 8'(n), 0);
                rdchk("R2 ded count", 6'h03, 32'(n));
                check("R4 irq_ded", {31'd0, irq_ded}, {31'd0, (thr != 0 && n >= thr)});
            end
            rdchk("R2 sec untouched", 6'h02, 0);
            rdchk("R2 adr untouched", 6'h04, 0);
        end

        // R3 saturation, R4 threshold above reachable count
        wr(6'h01, {7'd0, 1'b0, 4'd1, 4'd1, 16'd100});
        for (int n = 1; n <= 40; n++) begin
            fire(0, 8'h5, 8'd0);
            rdchk("R3 sec count", 6'h02, 32'((n > CMAX) ? CMAX : n));
            check("R4 irq_sec high thr", {31'd0, irq_sec}, 0);
        end
        wr(6'h01, {7'd0, 1'b0, 4'd1, 4'd1, 16'd31});
        check("R4 irq_sec at thr", {31'd0, irq_sec}, 1);

        // R5 trace order, full drop
        wr(6'h00, 32'h4);
        wr(6'h01, 32'h0011_0001);
        fire(2, 8'd10, 0); fire(2, 8'd20, 0); fire(2, 8'd10, 0);
        fire(2, 8'd30, 0); fire(2, 8'd40, 0); fire(2, 8'd50, 0);
        rdchk("R5 adr count", 6'h04, 6);
        rdchk("R5 adr level", 6'h07, 4);
        rdchk("R5 t0", tofs(2, 0), 10);
        rdchk("R5 t1", tofs(2, 1), 20);
        rdchk("R5 t2", tofs(2, 2), 10);
        rdchk("R5 t3", tofs(2, 3), 30);

        // R6 duplicate discard
        wr(6'h00, 32'h4);
        wr(6'h01, 32'h0111_0001);
        fire(2, 8'd10, 0); fire(2, 8'd20, 0); fire(2, 8'd10, 0);
        fire(2, 8'd20, 0); fire(2, 8'd30, 0);
        rdchk("R6 count", 6'h04, 5);
        rdchk("R6 level", 6'h07, 3);
        rdchk("R6 t0", tofs(2, 0), 10);
        rdchk("R6 t1", tofs(2, 1), 20);
        rdchk("R6 t2", tofs(2, 2), 30);
        rdchk("R6 t3", tofs(2, 3), 0);
        wr(6'h01, 32'h0011_0001);

        // R7 selective clear
        wr(6'h00, 32'h7);
        fire(0, 8'hA1, 0); fire(1, 8'hB2, 0); fire(2, 8'hC3, 0);
        check("R7 irq before", {29'd0, irq_sec, irq_ded, irq_adr}, 32'h7);
        wr(6'h00, 32'h2);
        rdchk("R7 ded count", 6'h03, 0);
        rdchk("R7 ded level", 6'h06, 0);
        rdchk("R7 ded trace", tofs(1, 0), 0);
        check("R7 irq after", {29'd0, irq_sec, irq_ded, irq_adr}, 32'h5);
        rdchk("R7 sec kept", 6'h02, 1);
        rdchk("R7 sec trace kept", tofs(0, 0), 32'hA1);
        rdchk("R7 adr kept", 6'h04, 1);
        rdchk("R7 adr trace kept", tofs(2, 0), 32'hC3);

        // R8 clear and event in same cycle
        @(negedge clk);
        sec_ev = 1; sec_addr = 8'h77; sec_bit = 0;
        reg_we = 1; reg_addr = 6'h00; reg_wdata = 32'h1;
        @(negedge clk);
        sec_ev = 0; reg_we = 0; reg_wdata = 0;
        rdchk("R8 count", 6'h02, 0);
        rdchk("R8 level", 6'h05, 0);
        rdchk("R8 trace", tofs(0, 0), 0);

        // R9 distribution
        wr(6'h00, 32'h8);
        fire(0, 8'h1, 8'd0);
        fire(0, 8'h1, 8'd31);
        fire(0, 8'h1, 8'd32);
        fire(0, 8'h1, 8'd136);
        fire(0, 8'h1, 8'd136);
        fire(0, 8'h1, 8'd200);
        rdchk("R9 w0", 6'd32, 32'h8000_0001);
        rdchk("R9 w1", 6'd33, 32'h0000_0001);
        rdchk("R9 w2", 6'd34, 0);
        rdchk("R9 w3", 6'd35, 0);
        rdchk("R9 w4", 6'd36, 32'h0000_0100);
        rd(6'h02, d);
        wr(6'h00, 32'h8);
        for (int w = 0; w < 5; w++) rdchk("R9 cleared", 6'(32 + w), 0);
        rdchk("R9 count untouched", 6'h02, d);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule